// File: doc/BRIEF.md
# Segmented-Bus Test Packet Generator

This block produces a stream of known test packets on a wide local packet bus made of parallel segments, ahead of a serial link controller. It holds all traffic back until the transceiver reports lock and the receiver reports lane alignment. It then sends a fixed number of equal-length packets and raises a sticky done flag after the last one has left. Every packet carries a channel number. In packet mode that number walks upward through 0 to 255 and wraps. In burst mode it alternates between two fixed values. The payload is a running byte counter, so a checker further down the path can rebuild and compare every byte.

The bus carries one beat per cycle. Segments in a beat are filled from segment 0 upward, with no gaps. A packet may end and the next one may start in the same beat. The packet length is chosen so that it spans an odd number of segments. The start and end markers therefore move across every segment position as the run proceeds. Backpressure freezes the generator for a cycle. If the link goes down, the packet already in progress is completed and no new one starts until the link returns. The packet count is kept across the outage.

Top module: `tpg_seg_gen`

## Requirements
- R1: No segment carries a start marker unless lock_i and align_i were both high at the clock edge that registered it. After reset no segment is enabled until both inputs have been seen high.
- R2: Exactly PKT_TOTAL packets are sent, where PKT_TOTAL is even and in 2..65534. After the last one no segment is ever enabled again.
- R3: In packet mode (CHAN_MODE = CH_PACKET), packet n carries channel n mod 256 on each of its segments, starting at 0.
- R4: In burst mode (CHAN_MODE = CH_BURST), even-numbered packets carry CHAN_A and odd-numbered packets carry CHAN_B.
- R5: Each packet holds PKT_BYTES bytes over ceil(PKT_BYTES/16) segments. Only the last segment has the end marker, and its empty count is the number of unused bytes (8 for the default of 72 bytes). Over a run, start and end markers appear on all four segment positions.
- R6: The enabled segments in a beat always form a contiguous run beginning at segment 0. Packets follow each other with no gap inside a beat while the link is up.
- R7: When ready_i is low at a clock edge, the next cycle has no segment enabled. In that cycle the start, end, empty, channel and data outputs keep their previous values.
- R8: Payload bytes count up from 0 across the whole run, modulo 256. Segment s occupies seg_data_o[s*128 +: 128], with its first byte in the most significant eight bits. Unused bytes in an end segment are zero.
- R9: If lock_i or align_i drops during a packet, that packet is still completed. No new packet starts while the link is down, and numbering continues from where it stopped.
- R10: done_o rises in the cycle that shows the end marker of the final packet and stays high until reset.
- R11: While rst_ni is low, all segment enables and done_o are zero.
- R12: The empty count of a segment is zero unless that segment carries the end marker.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lock_i | input | 1 | Transceiver lock status |
| align_i | input | 1 | Receive lane alignment status |
| ready_i | input | 1 | Downstream ready; low stalls the bus for the next cycle |
| seg_ena_o | output | NSEG | Per-segment valid |
| seg_sop_o | output | NSEG | Per-segment start of packet |
| seg_eop_o | output | NSEG | Per-segment end of packet |
| seg_mty_o | output | NSEG*4 | Per-segment empty byte count, meaningful with end marker |
| seg_chan_o | output | NSEG*8 | Per-segment channel number |
| seg_data_o | output | NSEG*128 | Per-segment payload |
| done_o | output | 1 | Sticky: all packets sent |

## Verification
A wrong position counter inside a packet shows up as a missing or early end marker within the next beat or two. A bad byte counter corrupts the next enabled segment's data. Both are caught on the first enabled segment after the fault, because every enabled segment is compared in order against the expected stream. A lost or doubled packet count moves every later channel number and ends the run early or late. That is seen at the next start marker and again when done_o rises. A gating fault in the link or ready logic shows up in the very next cycle as a start marker under link-down or an enabled segment after a stalled edge.

// File: rtl/tpg_pkg.sv
package tpg_pkg;

    typedef enum logic [1:0] {
        ST_WAIT = 2'd0,
        ST_SEND = 2'd1,
        ST_DONE = 2'd2
    } tpg_state_e;

    typedef enum logic {
        CH_PACKET = 1'b0,
        CH_BURST  = 1'b1
    } chan_mode_e;

endpackage

// File: rtl/tpg_chan_seq.sv
// Maps a packet index to its channel number; the mode picks the variant.
module tpg_chan_seq
    import tpg_pkg::*;
#(
    parameter chan_mode_e CHAN_MODE = CH_PACKET,
    parameter int         CNT_W     = 16,
    parameter logic [7:0] CHAN_A    = 8'd1,
    parameter logic [7:0] CHAN_B    = 8'd2
) (
    input  logic [CNT_W-1:0] pkt_idx_i,
    output logic [7:0]       chan_o
);
    generate
        if (CHAN_MODE == CH_BURST) begin : g_burst
            assign chan_o = pkt_idx_i[0] ? CHAN_B : CHAN_A;
        end else begin : g_packet
            assign chan_o = pkt_idx_i[7:0];
        end
    endgenerate
endmodule

// File: rtl/tpg_seg_fmt.sv
// Builds one segment's payload and empty count from a starting byte value.
module tpg_seg_fmt #(
    parameter int SEG_W      = 128,
    parameter int TAIL_BYTES = 8,
    parameter int MTY_W      = 4
) (
    input  logic             use_i,
    input  logic             tail_i,
    input  logic [7:0]       base_i,
    output logic [SEG_W-1:0] data_d,
    output logic [MTY_W-1:0] mty_d
);
    localparam int SEG_BYTES  = SEG_W / 8;
    localparam int TAIL_EMPTY = SEG_BYTES - TAIL_BYTES;

    always_comb begin
        data_d = '0;
        for (int k = 0; k < SEG_BYTES; k++) begin
            if (use_i && (!tail_i || k < TAIL_BYTES)) begin
                data_d[SEG_W-1-8*k -: 8] = base_i + 8'(k);
            end
        end
        mty_d = (use_i && tail_i) ? MTY_W'(TAIL_EMPTY) : '0;
    end
endmodule

// File: rtl/tpg_seg_gen.sv
module tpg_seg_gen
    import tpg_pkg::*;
#(
    parameter int         NSEG       = 4,
    parameter int         SEG_W      = 128,
    parameter int         PKT_BYTES  = 72,
    parameter int         PKT_TOTAL  = 16,
    parameter chan_mode_e CHAN_MODE  = CH_PACKET,
    parameter logic [7:0] CHAN_A     = 8'd10,
    parameter logic [7:0] CHAN_B     = 8'd20
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  lock_i,
    input  logic                  align_i,
    input  logic                  ready_i,
    output logic [NSEG-1:0]       seg_ena_o,
    output logic [NSEG-1:0]       seg_sop_o,
    output logic [NSEG-1:0]       seg_eop_o,
    output logic [NSEG*4-1:0]     seg_mty_o,
    output logic [NSEG*8-1:0]     seg_chan_o,
    output logic [NSEG*SEG_W-1:0] seg_data_o,
    output logic                  done_o
);
    localparam int SEG_BYTES  = SEG_W / 8;
    localparam int SPP        = (PKT_BYTES + SEG_BYTES - 1) / SEG_BYTES;
    localparam int TAIL_BYTES = PKT_BYTES - (SPP - 1) * SEG_BYTES;
    localparam int MTY_W      = 4;
    localparam int POS_W      = (SPP > 1) ? $clog2(SPP) : 1;
    localparam int CNT_W      = 16;

    typedef struct packed {
        tpg_state_e             st;
        logic                   mid;
        logic [POS_W-1:0]       pos;
        logic [CNT_W-1:0]       cnt;
        logic [7:0]             bc;
        logic                   done;
        logic [NSEG-1:0]        ena;
        logic [NSEG-1:0]        sop;
        logic [NSEG-1:0]        eop;
        logic [NSEG*MTY_W-1:0]  mty;
        logic [NSEG*8-1:0]      chan;
        logic [NSEG*SEG_W-1:0]  data;
    } gen_state_t;

    gen_state_t state_d, state_q;

    logic link_up;
    assign link_up = lock_i && align_i;

    // beat plan
    logic [NSEG-1:0]  p_use, p_sop, p_eop;
    logic [CNT_W-1:0] p_idx  [NSEG];
    logic [7:0]       p_base [NSEG];
    logic             e_mid;
    logic [POS_W-1:0] e_pos;
    logic [CNT_W-1:0] e_cnt;
    logic [7:0]       e_bc;

    always_comb begin
        logic             mid;
        logic [POS_W-1:0] pos;
        logic [CNT_W-1:0] cnt;
        logic [7:0]       bc;
        logic             halt;
        mid  = state_q.mid;
        pos  = state_q.pos;
        cnt  = state_q.cnt;
        bc   = state_q.bc;
        halt = !(state_q.st == ST_SEND && ready_i);
        p_use = '0;
        p_sop = '0;
        p_eop = '0;
        for (int s = 0; s < NSEG; s++) begin
            p_idx[s]  = '0;
            p_base[s] = '0;
        end
        for (int s = 0; s < NSEG; s++) begin
            if (!halt && !mid) begin
                if (link_up && cnt < CNT_W'(PKT_TOTAL)) begin
                    mid      = 1'b1;
                    pos      = '0;
                    p_sop[s] = 1'b1;
                    cnt      = cnt + 1'b1;
                end else begin
                    halt = 1'b1;
                end
            end
            if (!halt) begin
                p_use[s]  = 1'b1;
                p_idx[s]  = cnt - 1'b1;
                p_base[s] = bc;
                if (pos == POS_W'(SPP - 1)) begin
                    p_eop[s] = 1'b1;
                    bc       = bc + 8'(TAIL_BYTES);
                    mid      = 1'b0;
                    pos      = '0;
                end else begin
                    bc  = bc + 8'(SEG_BYTES);
                    pos = pos + 1'b1;
                end
            end
        end
        e_mid = mid;
        e_pos = pos;
        e_cnt = cnt;
        e_bc  = bc;
    end

    logic [7:0]       seg_chan_d [NSEG];
    logic [SEG_W-1:0] seg_data_d [NSEG];
    logic [MTY_W-1:0] seg_mty_d  [NSEG];

    generate
        for (genvar g = 0; g < NSEG; g++) begin : g_seg
            tpg_chan_seq #(
                .CHAN_MODE (CHAN_MODE),
                .CNT_W     (CNT_W),
                .CHAN_A    (CHAN_A),
                .CHAN_B    (CHAN_B)
            ) u_chan (
                .pkt_idx_i (p_idx[g]),
                .chan_o    (seg_chan_d[g])
            );
            tpg_seg_fmt #(
                .SEG_W      (SEG_W),
                .TAIL_BYTES (TAIL_BYTES),
                .MTY_W      (MTY_W)
            ) u_fmt (
                .use_i  (p_use[g]),
                .tail_i (p_eop[g]),
                .base_i (p_base[g]),
                .data_d (seg_data_d[g]),
                .mty_d  (seg_mty_d[g])
            );
        end
    endgenerate

    always_comb begin
        state_d = state_q;
        case (state_q.st)
            ST_WAIT: begin
                state_d.ena = '0;
                if (link_up) state_d.st = ST_SEND;
            end
            ST_SEND: begin
                if (ready_i) begin
                    state_d.ena = p_use;
                    state_d.sop = p_sop;
                    state_d.eop = p_eop;
                    for (int s = 0; s < NSEG; s++) begin
                        state_d.mty[s*MTY_W +: MTY_W] = seg_mty_d[s];
                        state_d.chan[s*8 +: 8]        = p_use[s] ? seg_chan_d[s] : 8'd0;
                        state_d.data[s*SEG_W +: SEG_W] = seg_data_d[s];
                    end
                    state_d.mid = e_mid;
                    state_d.pos = e_pos;
                    state_d.cnt = e_cnt;
                    state_d.bc  = e_bc;
                    if (!e_mid) begin
                        if (e_cnt == CNT_W'(PKT_TOTAL)) begin
                            state_d.st   = ST_DONE;
                            state_d.done = 1'b1;
                        end else if (!link_up) begin
                            state_d.st = ST_WAIT;
                        end
                    end
                end else begin
                    state_d.ena = '0;
                end
            end
            ST_DONE: state_d.ena = '0;
            default: state_d.st = ST_WAIT;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= '0;
        else         state_q <= state_d;
    end

    assign seg_ena_o  = state_q.ena;
    assign seg_sop_o  = state_q.sop;
    assign seg_eop_o  = state_q.eop;
    assign seg_mty_o  = state_q.mty;
    assign seg_chan_o = state_q.chan;
    assign seg_data_o = state_q.data;
    assign done_o     = state_q.done;

    // ---------------- assertions ----------------
    p_sop_link_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|(seg_sop_o & seg_ena_o)) |-> $past(lock_i && align_i));

    p_count_cap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        state_q.cnt <= CNT_W'(PKT_TOTAL));

    p_after_done_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(done_o) |-> (seg_ena_o == '0));

    p_contig_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((seg_ena_o & (seg_ena_o + 1'b1)) == '0));

    p_stall_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$past(ready_i) |-> (seg_ena_o == '0 && $stable(seg_data_o)
                             && $stable(seg_chan_o) && $stable(seg_sop_o)));

    p_done_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(done_o) |-> done_o);

    p_done_eop_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(done_o) |-> (|(seg_eop_o & seg_ena_o)));

    generate
        for (genvar a = 0; a < NSEG; a++) begin : g_chk
            p_mty_eop_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
                (seg_mty_o[a*MTY_W +: MTY_W] != '0) |-> seg_eop_o[a]);
            if (CHAN_MODE == CH_BURST) begin : g_bchk
                p_burst_chan_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
                    seg_ena_o[a] |-> (seg_chan_o[a*8 +: 8] == CHAN_A
                                      || seg_chan_o[a*8 +: 8] == CHAN_B));
            end
        end
    endgenerate

endmodule

// File: tb/tpg_seg_gen_test.sv
module tpg_seg_gen_test;
    import tpg_pkg::*;

    localparam int NSEG  = 4;
    localparam int SW    = 128;
    localparam int SB    = 16;
    localparam int SPP   = 5;
    localparam int TAILB = 8;
    localparam int TOT0  = 300;
    localparam int TOT1  = 10;
    localparam logic [7:0] CA = 8'h3C;
    localparam logic [7:0] CB = 8'hC3;

    typedef struct packed {
        logic       sop;
        logic       eop;
        logic [3:0] mty;
        logic [7:0] chan;
        logic [SW-1:0] data;
    } seg_t;

    logic clk = 1'b0, rst_n = 1'b0, lock = 1'b0, align = 1'b0, ready = 1'b0;
    always #2.5 clk = ~clk;

    logic [NSEG-1:0] ena0, sop0, eop0, ena1, sop1, eop1;
    logic [NSEG*4-1:0] mty0, mty1;
    logic [NSEG*8-1:0] chan0, chan1;
    logic [NSEG*SW-1:0] data0, data1;
    logic done0, done1;

    tpg_seg_gen #(.PKT_TOTAL(TOT0), .CHAN_MODE(CH_PACKET)) uut (
        .clk_i(clk), .rst_ni(rst_n), .lock_i(lock), .align_i(align), .ready_i(ready),
        .seg_ena_o(ena0), .seg_sop_o(sop0), .seg_eop_o(eop0), .seg_mty_o(mty0),
        .seg_chan_o(chan0), .seg_data_o(data0), .done_o(done0));

    tpg_seg_gen #(.PKT_TOTAL(TOT1), .CHAN_MODE(CH_BURST), .CHAN_A(CA), .CHAN_B(CB)) uut_b (
        .clk_i(clk), .rst_ni(rst_n), .lock_i(lock), .align_i(align), .ready_i(ready),
        .seg_ena_o(ena1), .seg_sop_o(sop1), .seg_eop_o(eop1), .seg_mty_o(mty1),
        .seg_chan_o(chan1), .seg_data_o(data1), .done_o(done1));

    seg_t q0[$], q1[$];
    int checks = 0, fails = 0;
    logic link_e = 1'b0, ready_e = 1'b0, mon_on = 1'b0;
    logic [NSEG-1:0] sop_seen = '0, eop_seen = '0;
    logic [NSEG*(2+4+8+SW)-1:0] prev0 = '0, prev1 = '0;

    always @(posedge clk) begin
        link_e  <= lock & align;
        ready_e <= ready;
    end

    task automatic fail_msg(input string tag, input string what,
                            input logic [SW-1:0] act, input logic [SW-1:0] exp);
        fails++;
        $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    endtask

    // driver side of the scoreboard: expected segment stream
    task automatic fill(input int w, input int total, input bit burst);
        logic [7:0] b = 8'd0;
        for (int n = 0; n < total; n++) begin
            logic [7:0] ch = burst ? ((n % 2) ? CB : CA) : 8'(n);
            for (int s = 0; s < SPP; s++) begin
                seg_t it;
                int nb = (s == SPP-1) ? TAILB : SB;
                it.sop  = (s == 0);
                it.eop  = (s == SPP-1);
                it.mty  = (s == SPP-1) ? 4'(SB - TAILB) : 4'd0;
                it.chan = ch;
                it.data = '0;
                for (int k = 0; k < nb; k++) begin
                    it.data[SW-1-8*k -: 8] = b;
                    b = b + 8'd1;
                end
                if (w == 0) q0.push_back(it); else q1.push_back(it);
            end
        end
    endtask

    task automatic check_inst(input int w, input logic [NSEG-1:0] ena, sop, eop,
                              input logic [NSEG*4-1:0] mty, input logic [NSEG*8-1:0] chan,
                              input logic [NSEG*SW-1:0] data, input logic done);
        logic [NSEG*(2+4+8+SW)-1:0] bund = {sop, eop, mty, chan, data};
        string ctag = (w == 0) ? "R3" : "R4";
        // R7: stalled edge gives an idle, frozen bus
        if (!ready_e) begin
            checks++;
            if (ena != '0) fail_msg("R7", "enable after stall", SW'(ena), '0);
            checks++;
            if (bund != ((w == 0) ? prev0 : prev1))
                fail_msg("R7", "outputs changed after stall", SW'(bund), SW'((w == 0) ? prev0 : prev1));
        end
        if (w == 0) prev0 = bund; else prev1 = bund;
        if (ena != '0) begin
            checks++;
            if ((ena & (ena + 1'b1)) != '0) fail_msg("R6", "non-contiguous enables", SW'(ena), '0);
        end
        for (int s = 0; s < NSEG; s++) begin
            if (ena[s]) begin
                seg_t e;
                if ((w == 0 ? q0.size() : q1.size()) == 0) begin
                    checks++;
                    fail_msg("R2", "segment beyond packet total", SW'(s), '0);
                end else begin
                    e = (w == 0) ? q0.pop_front() : q1.pop_front();
                    checks++;
                    if (sop[s] && !link_e) fail_msg("R1", "start with link down (R9)", 1, 0);
                    checks++;
                    if (sop[s] != e.sop || eop[s] != e.eop)
                        fail_msg("R5", "sop/eop", SW'({sop[s], eop[s]}), SW'({e.sop, e.eop}));
                    checks++;
                    if (mty[s*4 +: 4] != e.mty) fail_msg("R12", "empty count", SW'(mty[s*4 +: 4]), SW'(e.mty));
                    checks++;
                    if (chan[s*8 +: 8] != e.chan) fail_msg(ctag, "channel", SW'(chan[s*8 +: 8]), SW'(e.chan));
                    checks++;
                    if (data[s*SW +: SW] != e.data) fail_msg("R8", "payload", data[s*SW +: SW], e.data);
                    if (w == 0 && sop[s]) sop_seen[s] = 1'b1;
                    if (w == 0 && eop[s]) eop_seen[s] = 1'b1;
                end
            end
        end
        checks++;
        if (done != ((w == 0 ? q0.size() : q1.size()) == 0))
            fail_msg("R10", "done flag", SW'(done), SW'((w == 0 ? q0.size() : q1.size()) == 0));
    endtask

    // monitor side of the scoreboard
    always @(negedge clk) begin
        if (mon_on) begin
            check_inst(0, ena0, sop0, eop0, mty0, chan0, data0, done0);
            check_inst(1, ena1, sop1, eop1, mty1, chan1, data1, done1);
        end
    end

    initial begin
        logic [15:0] lfsr = 16'hACE1;
        int cyc = 0;
        fill(0, TOT0, 1'b0);
        fill(1, TOT1, 1'b1);
        repeat (4) @(negedge clk);
        // R11: reset state
        checks++;
        if (ena0 != '0 || ena1 != '0) fail_msg("R11", "enables in reset", SW'({ena0, ena1}), '0);
        checks++;
        if (done0 || done1) fail_msg("R11", "done in reset", SW'({done0, done1}), '0);
        ready = 1'b1;
        @(negedge clk);
        rst_n = 1'b1;
        mon_on = 1'b1;
        // R1: link down, then lock alone
        repeat (20) @(negedge clk);
        lock = 1'b1;
        repeat (10) @(negedge clk);
        checks++;
        if (q0.size() != TOT0 * SPP) fail_msg("R1", "traffic before alignment", SW'(q0.size()), SW'(TOT0 * SPP));
        align = 1'b1;
        while (!(done0 && done1) && cyc < 20000) begin
            @(negedge clk);
            cyc++;
            lfsr  = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            ready = (lfsr[1:0] != 2'b00);
            if (cyc == 60)  align = 1'b0;   // R9 outage
            if (cyc == 90)  align = 1'b1;
            if (cyc == 150) lock  = 1'b0;
            if (cyc == 173) lock  = 1'b1;
        end
        if (cyc >= 20000) begin
            fails++;
            $display("FAIL R2 watchdog: actual %0d cycles expected completion", cyc);
        end
        ready = 1'b1;
        repeat (20) @(negedge clk);
        checks++;
        if (q0.size() != 0 || q1.size() != 0)
            fail_msg("R2", "segments never sent", SW'(q0.size() + q1.size()), '0);
        checks++;
        if (sop_seen != '1) fail_msg("R5", "start positions covered", SW'(sop_seen), SW'(4'hF));
        checks++;
        if (eop_seen != '1) fail_msg("R5", "end positions covered", SW'(eop_seen), SW'(4'hF));
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule